// File: doc/BRIEF.md
# CAN Interrupt Identifier Encoder

This block holds the interrupt causes of a CAN controller with fifteen message objects and turns them into one registered 8-bit identifier code plus a single interrupt request line. A status-change cause and one pending bit per message object are collected here. The identifier always names the most urgent cause still outstanding, so software reads it, services that cause, acknowledges it, and reads again until the code returns to zero.

Causes are set by single-cycle event pulses from the protocol engine. The status-change cause is acknowledged by a read of the status register. A status update such as a good reception, a good transmission or a new error code sets it directly. A bus-off or warning transition sets it only while the error interrupt enable is on. Writing the status register has no effect on this cause. Each object's pending bit is cleared by its own clear strobe. A lower-ranked cause appears in the identifier only after every higher-ranked cause has been acknowledged.

Top module: `can_iid_top`

## Requirements
- R1: While reset is low at a clock edge, the identifier becomes 00h, the request line goes low, and all object pending bits go to 0.
- R2: A `stat_evt` pulse sets the status-change cause. A `bus_chg` pulse sets it only while `err_ie` is 1. The cause is shown as code 01h.
- R3: A `bus_chg` pulse while `err_ie` is 0 sets nothing. The identifier stays as it was.
- R4: A `stat_wr` strobe neither sets nor clears the status-change cause.
- R5: A `stat_rd` strobe clears the status-change cause. If the cause is set in the same cycle, the set wins.
- R6: Message object NOBJ (bit NOBJ-1 of the object vectors) reports code 02h. It ranks above every other message object.
- R7: Message object N, for N from 1 to NOBJ-1 (bit N-1), reports code 02h+N. The lower object number ranks higher.
- R8: The status-change cause ranks above all message objects.
- R9: `obj_set[i]` sets pending bit i and `obj_clr[i]` clears it. When both arrive in one cycle, the set wins. The bits are visible on `obj_pend` one clock after the strobe.
- R10: The identifier is registered. It shows the code of the causes pending one clock earlier, and 00h when none are pending. `irq` is 1 exactly when the identifier is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_evt | input | 1 | Status update pulse (rx/tx OK, error code update) |
| bus_chg | input | 1 | Bus-off or warning state change pulse |
| err_ie | input | 1 | Enable for bus state change interrupts |
| stat_wr | input | 1 | Write strobe of the status register |
| stat_rd | input | 1 | Read strobe of the status register (acknowledge) |
| obj_set | input | NOBJ | Per-object pending set pulses, bit i = object i+1 |
| obj_clr | input | NOBJ | Per-object pending clear strobes, bit i = object i+1 |
| int_id | output | ID_W | Registered interrupt identifier code |
| irq | output | 1 | Combined interrupt request |
| obj_pend | output | NOBJ | Object pending bits |

## Verification
The bench builds the block with its defaults, NOBJ = 15 and ID_W = 8. With these values every code from 00h to 10h can appear, including the last-object code 02h and the top object-1 code 03h. Sparse random pulses make many causes overlap, so the ranking is exercised while several causes are pending at once. Set and clear collisions are also produced. Directed steps cover the gated bus-state change, status writes, and a status read that coincides with a new status event.

// File: rtl/can_iid_pkg.sv
// Shared parameters and code constants for the CAN interrupt identifier
// encoder. Assumes identifier codes fit in ID_W bits (NOBJ + 2 < 2**ID_W).
package can_iid_pkg;
    localparam int unsigned IID_W_DEF   = 8;
    localparam int unsigned NOBJ_DEF    = 15;
    localparam int unsigned CODE_IDLE   = 0;
    localparam int unsigned CODE_STATUS = 1;
    localparam int unsigned CODE_LAST   = 2;
endpackage

// File: rtl/can_iid_pend.sv
// Per-object pending bits. Each bit is set by its event pulse and cleared
// by its clear strobe; set wins over clear. Synchronous active-low reset.
module can_iid_pend #(
    parameter int unsigned NOBJ = can_iid_pkg::NOBJ_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOBJ-1:0] set_i,
    input  logic [NOBJ-1:0] clr_i,
    output logic [NOBJ-1:0] pend_o
);
    for (genvar i = 0; i < NOBJ; i++) begin : g_bit
        // Holds the pending state of object i+1.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_o[i] <= 1'b0;
            else if (set_i[i]) pend_o[i] <= 1'b1;
            else if (clr_i[i]) pend_o[i] <= 1'b0;
        end

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]);
        p_clr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    end
endmodule

// File: rtl/can_iid_stat.sv
// Status-change cause. Set by a status update or by a bus state change
// while its enable is on; cleared only by a status register read.
// Status writes are accepted on the port but have no effect here.
module can_iid_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_evt,
    input  logic bus_chg,
    input  logic err_ie,
    input  logic stat_wr,
    input  logic stat_rd,
    output logic pend_o
);
    logic set_w;

    // Qualify the bus state change with its enable.
    assign set_w = stat_evt | (bus_chg & err_ie);

    // Holds the status-change cause; set wins over the read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (set_w)   pend_o <= 1'b1;
        else if (stat_rd) pend_o <= 1'b0;
    end

    p_wr_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_rd && !stat_evt && !bus_chg) |=> $stable(pend_o));
    p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_evt && !bus_chg) |=> !pend_o);
    p_gated_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && bus_chg && !err_ie && !stat_evt) |=> !pend_o);
endmodule

// File: rtl/can_iid_prio.sv
// Combinational ranking of pending causes into an identifier code:
// status first, then the last object (code 2), then objects 1..NOBJ-1
// with the lower number first (code 2 + N). Assumes NOBJ >= 2.
module can_iid_prio #(
    parameter int unsigned NOBJ = can_iid_pkg::NOBJ_DEF,
    parameter int unsigned ID_W = can_iid_pkg::IID_W_DEF
) (
    input  logic            stat_i,
    input  logic [NOBJ-1:0] pend_i,
    output logic [ID_W-1:0] code_o
);
    localparam logic [ID_W-1:0] C_IDLE = ID_W'(can_iid_pkg::CODE_IDLE);
    localparam logic [ID_W-1:0] C_STAT = ID_W'(can_iid_pkg::CODE_STATUS);
    localparam logic [ID_W-1:0] C_LAST = ID_W'(can_iid_pkg::CODE_LAST);

    // Pick the highest ranked pending cause; later assignments win.
    always_comb begin
        code_o = C_IDLE;
        for (int i = NOBJ - 2; i >= 0; i--) begin
            if (pend_i[i]) code_o = ID_W'(i + 3);
        end
        if (pend_i[NOBJ-1]) code_o = C_LAST;
        if (stat_i)         code_o = C_STAT;
    end
endmodule

// File: rtl/can_iid_top.sv
// CAN interrupt identifier encoder top. Collects status and per-object
// causes, ranks them, and registers the resulting identifier one clock
// after the pending state. irq is high while the identifier is non-zero.
module can_iid_top #(
    parameter int unsigned NOBJ = can_iid_pkg::NOBJ_DEF,
    parameter int unsigned ID_W = can_iid_pkg::IID_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_evt,
    input  logic            bus_chg,
    input  logic            err_ie,
    input  logic            stat_wr,
    input  logic            stat_rd,
    input  logic [NOBJ-1:0] obj_set,
    input  logic [NOBJ-1:0] obj_clr,
    output logic [ID_W-1:0] int_id,
    output logic            irq,
    output logic [NOBJ-1:0] obj_pend
);
    logic            stat_pend;
    logic [ID_W-1:0] code_w;

    can_iid_stat u_stat (
        .clk(clk), .rst_n(rst_n), .stat_evt(stat_evt), .bus_chg(bus_chg),
        .err_ie(err_ie), .stat_wr(stat_wr), .stat_rd(stat_rd),
        .pend_o(stat_pend)
    );

    can_iid_pend #(.NOBJ(NOBJ)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(obj_set), .clr_i(obj_clr),
        .pend_o(obj_pend)
    );

    can_iid_prio #(.NOBJ(NOBJ), .ID_W(ID_W)) u_prio (
        .stat_i(stat_pend), .pend_i(obj_pend), .code_o(code_w)
    );

    // Register the ranked code as the visible identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) int_id <= '0;
        else        int_id <= code_w;
    end

    // Request line follows the identifier.
    assign irq = |int_id;

    p_status_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pend |=> (int_id == ID_W'(1)));
    p_last_obj_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pend && obj_pend[NOBJ-1]) |=> (int_id == ID_W'(2)));
    p_idle_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pend && obj_pend == '0) |=> (int_id == '0 && !irq));
endmodule

// File: tb/test_can_iid_top.sv
`timescale 1ns/1ps
module test_can_iid_top;
    localparam int NOBJ = 15;
    localparam int ID_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stat_evt = 0, bus_chg = 0, err_ie = 0, stat_wr = 0, stat_rd = 0;
    logic [NOBJ-1:0] obj_set = '0, obj_clr = '0;
    logic [ID_W-1:0] int_id;
    logic            irq;
    logic [NOBJ-1:0] obj_pend;

    int n_chk = 0, n_fail = 0;
    logic            m_stat = 0;
    logic [NOBJ-1:0] m_pend = '0;
    logic [ID_W-1:0] exp_id = '0;

    can_iid_top #(.NOBJ(NOBJ), .ID_W(ID_W)) i_can_iid_top (
        .clk(clk), .rst_n(rst_n), .stat_evt(stat_evt), .bus_chg(bus_chg),
        .err_ie(err_ie), .stat_wr(stat_wr), .stat_rd(stat_rd),
        .obj_set(obj_set), .obj_clr(obj_clr), .int_id(int_id), .irq(irq),
        .obj_pend(obj_pend)
    );

    always #2 clk = ~clk;

    // Reference ranking from the requirements (R6, R7, R8).
    function automatic logic [ID_W-1:0] ref_code(logic s, logic [NOBJ-1:0] p);
        if (s) return ID_W'(1);
        if (p[NOBJ-1]) return ID_W'(2);
        for (int n = 1; n < NOBJ; n++) if (p[n-1]) return ID_W'(n + 2);
        return '0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: model update, then compare all outputs after the edge.
    task automatic step(string tag);
        logic            ns;
        logic [NOBJ-1:0] np;
        string           t;
        exp_id = rst_n ? ref_code(m_stat, m_pend) : '0;
        ns = !rst_n ? 1'b0 : (stat_evt | (bus_chg & err_ie)) ? 1'b1 : stat_rd ? 1'b0 : m_stat;
        np = !rst_n ? '0 : (obj_set | (m_pend & ~obj_clr));
        @(posedge clk);
        m_stat = ns;
        m_pend = np;
        @(negedge clk);
        t = (tag != "") ? tag : (exp_id == 0) ? "R10" : (exp_id == 1) ? "R8" :
            (exp_id == 2) ? "R6" : "R7";
        check({t, " id"}, int_id, exp_id);
        check("R10 irq", irq, exp_id != 0);
        check("R9 pend", obj_pend, m_pend);
    endtask

    task automatic idle_in();
        stat_evt = 0; bus_chg = 0; stat_wr = 0; stat_rd = 0; obj_set = '0; obj_clr = '0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1;
        step("R1");
        // R3: gated bus change does nothing
        bus_chg = 1; err_ie = 0; step("R3"); idle_in(); step("R3"); step("R3");
        // R2: enabled bus change sets status
        bus_chg = 1; err_ie = 1; step("R2"); idle_in(); step("R2"); step("R2");
        // R4: write does not clear
        stat_wr = 1; step("R4"); idle_in(); step("R4"); step("R4");
        // R5: read clears; read with event keeps
        stat_rd = 1; stat_evt = 1; step("R5"); idle_in(); step("R5"); step("R5");
        stat_rd = 1; step("R5"); idle_in(); step("R5"); step("R5");
        // R4: write does not set
        stat_wr = 1; step("R4"); idle_in(); step("R4"); step("R4");
        // R7/R6: objects 14, 1, then last object
        obj_set[13] = 1; step("R7"); idle_in(); step("R7"); step("R7");
        obj_set[0] = 1; step("R7"); idle_in(); step("R7"); step("R7");
        obj_set[NOBJ-1] = 1; step("R6"); idle_in(); step("R6"); step("R6");
        // R9: set and clear together, then clear in order
        obj_set[5] = 1; obj_clr[5] = 1; step("R9"); idle_in(); step("R9");
        obj_clr[NOBJ-1] = 1; step("R6"); idle_in(); step("R7"); step("R7");
        obj_clr = '1; step("R9"); idle_in(); step("R10"); step("R10");
        // Random phase
        for (int k = 0; k < 3000; k++) begin
            stat_evt = ($urandom % 16) == 0;
            bus_chg  = ($urandom % 16) == 0;
            err_ie   = $urandom % 2;
            stat_wr  = ($urandom % 8) == 0;
            stat_rd  = ($urandom % 6) == 0;
            obj_set  = NOBJ'($urandom & $urandom & $urandom & $urandom);
            obj_clr  = NOBJ'($urandom & $urandom);
            step("");
        end
        idle_in();
        rst_n = 0; step("R1"); step("R1");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule